// File: doc/BRIEF.md
# Paged LCD Refresh Streamer

This block moves a 128-column, 64-row monochrome image from a strip buffer into a page-addressed LCD controller. The controller works in pages: one page is 8 pixel rows, stored as one byte per column. For each page the block sends a short header in command mode (A0 low). The header sets the column address to zero and then selects the page. The block then raises A0 and streams the column bytes. Chip select (active low) stays asserted for the whole page and is released after the last byte. Bytes leave through a valid/ready handshake to a serial transmitter. Both the initialization sequence and the shifter itself sit outside this block.

The image reaches the block strip by strip through a small dual-port buffer that a renderer refills. The block shows the index of the strip it wants and waits for a go pulse. It then reads the buffer, which has one cycle of read latency, and prefetches far enough ahead that the transmitter never waits for data. When the strip has been sent it pulses a strip-done output.

A mode input, sampled when a frame starts, picks between two strip sizes:
- 8-row strips: one page each, eight strips per frame.
- 16-row strips: two pages each, four strips per frame. The lower half of the buffer goes to the even page and the upper half to the odd page.

A frame-start pulse is accepted only while the block is idle and the busy input is low. A frame-done pulse marks the end of the refresh.

Top module: `lcd_page_streamer`

## Requirements
- R1: Every page starts with three command bytes sent with A0 low, in this order: 0x10, then 0x00, then 0xB0 OR'd with the page number in bits 2:0.
- R2: After the three header bytes, exactly 128 bytes are sent with A0 high. Data byte k of a page is the buffer byte at address h*128 + k, where h is the page's half within its strip.
- R3: Chip select (low = selected) goes low before the first header byte and stays low through the last data byte of the page. It goes high for at least one cycle between pages, so it rises once per page. The valid output is never high while chip select is high.
- R4: With the mode input low, strip s is sent as page s from buffer addresses 0..127, and the frame is made of 8 strips.
- R5: With the mode input high, strip s is sent as page 2s from addresses 0..127 and then as page 2s+1 from addresses 128..255. Each of the two pages has its own header. The frame is made of 4 strips.
- R6: The block shows the wanted strip index and starts that strip only on a go pulse received while it is waiting. A go pulse at any other time has no effect. After the last data byte of a strip is accepted, strip-done is high for exactly one cycle.
- R7: A frame-start pulse is ignored while busy is high or while a refresh is in progress. The mode input is sampled only when a start is accepted.
- R8: Frame-done is high for one cycle, two cycles after the last data byte of the frame is accepted, and it coincides with the last strip-done.
- R9: While valid is high and ready is low, the valid output, the byte and A0 all hold their values.
- R10: With ready held high, the 128 data bytes of a page are accepted on consecutive cycles.
- R11: After reset, valid, read enable, strip-done and frame-done are low, chip select is high and A0 is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start_i | input | 1 | Pulse that requests a full refresh |
| busy_i | input | 1 | While high, start pulses are ignored |
| dbl_mode_i | input | 1 | 1 selects 16-row strips (two pages per strip) |
| strip_go_i | input | 1 | Pulse from the renderer: the requested strip is in the buffer |
| strip_idx_o | output | 3 | Index of the strip the block wants or is sending |
| strip_done_o | output | 1 | One-cycle pulse when a strip has been sent |
| frame_done_o | output | 1 | One-cycle pulse when the frame has been sent |
| rd_en_o | output | 1 | Buffer read enable |
| rd_addr_o | output | 8 | Buffer read address |
| rd_data_i | input | 8 | Buffer read data, valid one cycle after rd_en_o |
| tx_valid_o | output | 1 | Byte valid toward the transmitter |
| tx_data_o | output | 8 | Byte toward the transmitter |
| tx_a0_o | output | 1 | A0 level for the byte (0 command, 1 data) |
| tx_ready_i | input | 1 | Transmitter accepts the byte |
| cs_n_o | output | 1 | Controller chip select, active low |

## Verification
Buffer data is due one cycle after each read enable, and the bench's buffer model returns it at exactly that edge. Outgoing bytes are not checked at fixed cycles. Each accepted byte is captured on its handshake together with A0, chip select and the cycle number, and the bench then compares the captured stream against the header and data it computes for each page. Timing is checked from those recorded cycle numbers: frame-done must appear at the second sample point after the last accepted byte, and with ready held high the data bytes of a page must carry consecutive cycle numbers. The strip index is checked before each go pulse. Ignored stimuli are checked by confirming that no byte was accepted and no strip-done occurred in the cycles that follow.

// File: rtl/lcdpg_pkg.sv
package lcdpg_pkg;

    // One entry of the outgoing byte stream: the byte and its A0 level.
    typedef struct packed {
        logic       a0;
        logic [7:0] val;
    } lcd_byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSTRIP,
        ST_CMD,
        ST_DATA,
        ST_GAP
    } seq_state_e;

    localparam logic [7:0] CMD_COL_HI  = 8'h10;
    localparam logic [7:0] CMD_COL_LO  = 8'h00;
    localparam logic [7:0] CMD_PAGESEL = 8'hB0;
    localparam logic [1:0] HDR_LAST    = 2'd2;

    // Header byte for position idx of a page header.
    function automatic logic [7:0] hdr_byte(input logic [1:0] idx, input logic [3:0] page);
        case (idx)
            2'd0:    return CMD_COL_HI;
            2'd1:    return CMD_COL_LO;
            default: return CMD_PAGESEL | {4'h0, page};
        endcase
    endfunction

endpackage

// File: rtl/lcdpg_outq.sv
module lcdpg_outq
    import lcdpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       push_cmd,
    input  logic [7:0] cmd_val,
    input  logic       rd_issue,
    input  logic [7:0] rd_data,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       tx_a0,
    output logic       slot_ok,
    output logic       rd_ok,
    output logic       pop_data
);

    lcd_byte_t out_q, hold_q, out_n, hold_n;
    logic      out_v, hold_v, land_v;
    logic      out_vn, hold_vn;
    logic      fire;
    logic [1:0] occ;

    assign fire     = out_v & tx_ready;
    assign pop_data = fire & out_q.a0;
    assign tx_valid = out_v;
    assign tx_data  = out_q.val;
    assign tx_a0    = out_q.a0;

    // Entries held or in flight, after this cycle's pop.
    assign occ     = {1'b0, out_v} + {1'b0, hold_v} + {1'b0, land_v} - {1'b0, fire};
    assign rd_ok   = (occ < 2'd2);
    assign slot_ok = !hold_v && !land_v && (!out_v || fire);

    always_comb begin
        out_n   = out_q;
        out_vn  = out_v;
        hold_n  = hold_q;
        hold_vn = hold_v;
        if (fire) begin
            if (hold_v) begin
                out_n   = hold_q;
                hold_vn = 1'b0;
            end else begin
                out_vn = 1'b0;
            end
        end
        if (land_v) begin
            if (!out_vn) begin
                out_n  = '{a0: 1'b1, val: rd_data};
                out_vn = 1'b1;
            end else begin
                hold_n  = '{a0: 1'b1, val: rd_data};
                hold_vn = 1'b1;
            end
        end
        if (push_cmd) begin
            out_n  = '{a0: 1'b0, val: cmd_val};
            out_vn = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            hold_q <= '0;
            out_v  <= 1'b0;
            hold_v <= 1'b0;
            land_v <= 1'b0;
        end else begin
            out_q  <= out_n;
            hold_q <= hold_n;
            out_v  <= out_vn;
            hold_v <= hold_vn;
            land_v <= rd_issue;
        end
    end

endmodule

// File: rtl/lcdpg_seq.sv
module lcdpg_seq
    import lcdpg_pkg::*;
#(
    parameter  int COLS   = 128,
    parameter  int PAGES  = 8,
    localparam int COL_W  = $clog2(COLS),
    localparam int PG_W   = $clog2(PAGES),
    localparam int ADDR_W = COL_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              busy,
    input  logic              dbl_mode,
    input  logic              strip_go,
    input  logic              slot_ok,
    input  logic              rd_ok,
    input  logic              pop_data,
    output logic              push_cmd,
    output logic [7:0]        cmd_val,
    output logic              rd_issue,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [PG_W-1:0]   strip_idx,
    output logic              strip_done,
    output logic              frame_done,
    output logic              cs_n
);

    localparam logic [COL_W:0]  CNT_END  = (COL_W + 1)'(COLS);
    localparam logic [COL_W:0]  CNT_LAST = (COL_W + 1)'(COLS - 1);
    localparam logic [PG_W-1:0] LAST_ONE = PG_W'(PAGES - 1);
    localparam logic [PG_W-1:0] LAST_DBL = PG_W'(PAGES / 2 - 1);

    seq_state_e      state;
    logic [PG_W-1:0] strip, page, last_strip;
    logic            half, dbl_q;
    logic [1:0]      hdr_idx;
    logic [COL_W:0]  rd_cnt, acc_cnt;

    assign page       = dbl_q ? {strip[PG_W-2:0], half} : strip;
    assign last_strip = dbl_q ? LAST_DBL : LAST_ONE;
    assign cmd_val    = hdr_byte(hdr_idx, 4'(page));
    assign push_cmd   = (state == ST_CMD) && slot_ok;
    assign rd_issue   = (state == ST_DATA) && (rd_cnt != CNT_END) && rd_ok;
    assign rd_addr    = {half, rd_cnt[COL_W-1:0]};
    assign strip_idx  = strip;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            strip      <= '0;
            half       <= 1'b0;
            dbl_q      <= 1'b0;
            hdr_idx    <= '0;
            rd_cnt     <= '0;
            acc_cnt    <= '0;
            cs_n       <= 1'b1;
            strip_done <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            strip_done <= 1'b0;
            frame_done <= 1'b0;
            if (rd_issue) rd_cnt <= rd_cnt + 1'b1;
            case (state)
                ST_IDLE: begin
                    if (frame_start && !busy) begin
                        dbl_q <= dbl_mode;
                        strip <= '0;
                        half  <= 1'b0;
                        state <= ST_WSTRIP;
                    end
                end
                ST_WSTRIP: begin
                    if (strip_go) begin
                        cs_n    <= 1'b0;
                        hdr_idx <= '0;
                        state   <= ST_CMD;
                    end
                end
                ST_CMD: begin
                    if (push_cmd) begin
                        hdr_idx <= hdr_idx + 1'b1;
                        if (hdr_idx == HDR_LAST) begin
                            rd_cnt  <= '0;
                            acc_cnt <= '0;
                            state   <= ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    if (pop_data) begin
                        acc_cnt <= acc_cnt + 1'b1;
                        if (acc_cnt == CNT_LAST) begin
                            cs_n  <= 1'b1;
                            state <= ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    if (dbl_q && !half) begin
                        half    <= 1'b1;
                        hdr_idx <= '0;
                        cs_n    <= 1'b0;
                        state   <= ST_CMD;
                    end else begin
                        strip_done <= 1'b1;
                        half       <= 1'b0;
                        if (strip == last_strip) begin
                            frame_done <= 1'b1;
                            state      <= ST_IDLE;
                        end else begin
                            strip <= strip + 1'b1;
                            state <= ST_WSTRIP;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lcd_page_streamer.sv
module lcd_page_streamer
    import lcdpg_pkg::*;
#(
    parameter  int COLS   = 128,
    parameter  int PAGES  = 8,
    localparam int PG_W   = $clog2(PAGES),
    localparam int ADDR_W = $clog2(COLS) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start_i,
    input  logic              busy_i,
    input  logic              dbl_mode_i,
    input  logic              strip_go_i,
    output logic [PG_W-1:0]   strip_idx_o,
    output logic              strip_done_o,
    output logic              frame_done_o,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i,
    output logic              tx_valid_o,
    output logic [7:0]        tx_data_o,
    output logic              tx_a0_o,
    input  logic              tx_ready_i,
    output logic              cs_n_o
);

    logic       push_cmd, slot_ok, rd_ok, pop_data;
    logic [7:0] cmd_val;

    lcdpg_seq #(.COLS(COLS), .PAGES(PAGES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start_i),
        .busy       (busy_i),
        .dbl_mode   (dbl_mode_i),
        .strip_go   (strip_go_i),
        .slot_ok    (slot_ok),
        .rd_ok      (rd_ok),
        .pop_data   (pop_data),
        .push_cmd   (push_cmd),
        .cmd_val    (cmd_val),
        .rd_issue   (rd_en_o),
        .rd_addr    (rd_addr_o),
        .strip_idx  (strip_idx_o),
        .strip_done (strip_done_o),
        .frame_done (frame_done_o),
        .cs_n       (cs_n_o)
    );

    lcdpg_outq u_outq (
        .clk     (clk),
        .rst     (rst),
        .push_cmd(push_cmd),
        .cmd_val (cmd_val),
        .rd_issue(rd_en_o),
        .rd_data (rd_data_i),
        .tx_ready(tx_ready_i),
        .tx_valid(tx_valid_o),
        .tx_data (tx_data_o),
        .tx_a0   (tx_a0_o),
        .slot_ok (slot_ok),
        .rd_ok   (rd_ok),
        .pop_data(pop_data)
    );

endmodule

// File: rtl/lcdpg_chk.sv
module lcdpg_chk #(
    parameter int PG_W   = 3,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_start_i,
    input logic              busy_i,
    input logic              dbl_mode_i,
    input logic              strip_go_i,
    input logic [PG_W-1:0]   strip_idx_o,
    input logic              strip_done_o,
    input logic              frame_done_o,
    input logic              rd_en_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic [7:0]        rd_data_i,
    input logic              tx_valid_o,
    input logic [7:0]        tx_data_o,
    input logic              tx_a0_o,
    input logic              tx_ready_i,
    input logic              cs_n_o
);

    // R9
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o) && $stable(tx_a0_o)));

    // R3
    cs_cover_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid_o |-> !cs_n_o);

    // R8
    frame_end_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done_o |-> strip_done_o);

    // R6
    strip_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        strip_done_o |=> !strip_done_o);

    // R2
    read_window_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en_o |-> !cs_n_o);

    // R8
    frame_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done_o |=> !frame_done_o);

endmodule

bind lcd_page_streamer lcdpg_chk #(.PG_W(PG_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/lcd_page_streamer_tb.sv
module lcd_page_streamer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int COLS       = 128;
    localparam int PAGES      = 8;
    localparam int PG_BYTES   = COLS + 3;
    localparam int NVEC       = 5;
    // {dbl_mode, ready pattern, data seed}
    localparam logic [10:0] VEC [NVEC] = '{
        {1'b0, 2'd0, 8'h00},
        {1'b1, 2'd0, 8'h5A},
        {1'b0, 2'd1, 8'h33},
        {1'b1, 2'd2, 8'hC4},
        {1'b0, 2'd2, 8'h91}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_start = 1'b0, busy = 1'b0, dbl = 1'b0, strip_go = 1'b0;
    logic [2:0] strip_idx;
    logic       strip_done, frame_done, rd_en, tx_valid, tx_a0, cs_n;
    logic [7:0] rd_addr, tx_data;
    logic [7:0] rd_data = 8'h00;
    logic       tx_ready = 1'b0;

    lcd_page_streamer #(.COLS(COLS), .PAGES(PAGES)) u_dut (
        .clk(clk), .rst(rst), .frame_start_i(frame_start), .busy_i(busy),
        .dbl_mode_i(dbl), .strip_go_i(strip_go), .strip_idx_o(strip_idx),
        .strip_done_o(strip_done), .frame_done_o(frame_done), .rd_en_o(rd_en),
        .rd_addr_o(rd_addr), .rd_data_i(rd_data), .tx_valid_o(tx_valid),
        .tx_data_o(tx_data), .tx_a0_o(tx_a0), .tx_ready_i(tx_ready), .cs_n_o(cs_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Strip buffer model, one cycle of read latency.
    logic [7:0] mem [0:255];
    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    int checks = 0, fails = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor and transmitter model.
    logic [7:0]  cap_b   [0:4095];
    logic        cap_a0  [0:4095];
    logic        cap_cs  [0:4095];
    int          cap_cyc [0:4095];
    int          cap_n = 0, cs_rise = 0, sd_cnt = 0, fd_cnt = 0, fd_cyc = 0, cyc = 0;
    logic [1:0]  rmode = 2'd0;
    logic [15:0] lfsr = 16'hACE1;
    logic        cs_prev = 1'b1;

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            case (rmode)
                2'd0:    tx_ready = 1'b1;
                2'd1:    tx_ready = ~tx_ready;
                default: begin
                    lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    tx_ready = lfsr[0] | lfsr[5];
                end
            endcase
            if (!rst) begin
                if (tx_valid && tx_ready && cap_n < 4096) begin
                    cap_b[cap_n]   = tx_data;
                    cap_a0[cap_n]  = tx_a0;
                    cap_cs[cap_n]  = cs_n;
                    cap_cyc[cap_n] = cyc;
                    cap_n++;
                end
                if (!cs_prev && cs_n) cs_rise++;
                cs_prev = cs_n;
                if (strip_done) sd_cnt++;
                if (frame_done) begin
                    fd_cnt++;
                    fd_cyc = cyc;
                end
            end
        end
    end

    function automatic logic [7:0] pat(input logic [7:0] seed, input int strip, input int addr);
        return 8'(addr * 7 + strip * 29) ^ seed;
    endfunction

    task automatic clear_mon();
        cap_n = 0; cs_rise = 0; sd_cnt = 0; fd_cnt = 0; fd_cyc = 0;
    endtask

    task automatic run_frame(input bit dm, input logic [1:0] rm, input logic [7:0] seed);
        int nstr;
        nstr = dm ? PAGES / 2 : PAGES;
        @(negedge clk);
        clear_mon();
        rmode = rm;
        dbl = dm;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int s = 0; s < nstr; s++) begin
            int t;
            for (int a = 0; a < 256; a++) mem[a] = pat(seed, s, a);
            repeat (2) @(negedge clk);
            chk(strip_idx == 3'(s), "R6", "strip index shown before go", int'(strip_idx), s);
            strip_go = 1'b1;
            @(negedge clk);
            strip_go = 1'b0;
            if (s == 0) begin
                // R7: start during refresh is ignored; mode change is not picked up
                dbl = ~dm;
                frame_start = 1'b1;
                @(negedge clk);
                frame_start = 1'b0;
            end
            t = 0;
            while (!strip_done && t < 8000) begin
                @(negedge clk);
                t++;
            end
        end
        repeat (4) @(negedge clk);
        // Compare the captured stream.
        chk(cap_n == PAGES * PG_BYTES, "R2", "bytes per frame", cap_n, PAGES * PG_BYTES);
        for (int p = 0; p < PAGES; p++) begin
            int  base, s, h, bad, badk;
            bit  hok, tok;
            base = p * PG_BYTES;
            s = dm ? p / 2 : p;
            h = dm ? p % 2 : 0;
            hok = cap_b[base] == 8'h10 && cap_b[base + 1] == 8'h00 &&
                  cap_b[base + 2] == (8'hB0 | 8'(p)) &&
                  !cap_a0[base] && !cap_a0[base + 1] && !cap_a0[base + 2] &&
                  !cap_cs[base] && !cap_cs[base + 1] && !cap_cs[base + 2];
            chk(hok, "R1", "page header", int'(cap_b[base + 2]), int'(8'hB0 | 8'(p)));
            bad = 0; badk = -1;
            tok = 1'b1;
            for (int k = 0; k < COLS; k++) begin
                if (cap_b[base + 3 + k] != pat(seed, s, h * COLS + k) || !cap_a0[base + 3 + k]
                    || cap_cs[base + 3 + k]) begin
                    bad++;
                    if (badk < 0) badk = k;
                end
                if (k > 0 && cap_cyc[base + 3 + k] != cap_cyc[base + 2 + k] + 1) tok = 1'b0;
            end
            if (dm) chk(bad == 0, "R5", "double-height page data mismatches", bad, 0);
            else    chk(bad == 0, "R4", "single-height page data mismatches", bad, 0);
            if (bad != 0)
                chk(1'b0, "R2", "first bad column", badk, -1);
            if (rm == 2'd0)
                chk(tok, "R10", "back-to-back data acceptance", int'(tok), 1);
        end
        chk(cs_rise == PAGES, "R3", "chip select releases per frame", cs_rise, PAGES);
        chk(sd_cnt == nstr, "R6", "strip-done pulses", sd_cnt, nstr);
        chk(fd_cnt == 1, "R8", "frame-done pulses", fd_cnt, 1);
        if (cap_n > 0)
            chk(fd_cyc == cap_cyc[cap_n - 1] + 2, "R8", "frame-done cycle", fd_cyc, cap_cyc[cap_n - 1] + 2);
    endtask

    task automatic reset_check();
        chk(!tx_valid && !rd_en && !strip_done && !frame_done && cs_n && !tx_a0, "R11", "reset state",
            int'({tx_valid, rd_en, strip_done, frame_done, cs_n, tx_a0}), 6'b000010);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        reset_check();

        // R7: start while busy is ignored
        clear_mon();
        busy = 1'b1;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            strip_go = 1'b1;
            @(negedge clk);
            strip_go = 1'b0;
            repeat (5) @(negedge clk);
        end
        chk(cap_n == 0 && sd_cnt == 0 && cs_n, "R7", "bytes after start while busy", cap_n, 0);
        busy = 1'b0;

        // R6: go pulse while idle has no effect, and a later start still waits for go
        clear_mon();
        strip_go = 1'b1;
        @(negedge clk);
        strip_go = 1'b0;
        repeat (10) @(negedge clk);
        chk(cap_n == 0 && cs_n, "R6", "bytes after idle go pulse", cap_n, 0);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        repeat (20) @(negedge clk);
        chk(cap_n == 0 && cs_n, "R6", "bytes before go after start", cap_n, 0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        reset_check();

        for (int v = 0; v < NVEC; v++)
            run_frame(VEC[v][10], VEC[v][9:8], VEC[v][7:0]);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual %0d expected %0d", 150000, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule